// File: doc/BRIEF.md
# Linked-List Descriptor Queue Manager

This block keeps a set of hardware packet queues, each built as a singly linked list of descriptors. The lists share one link memory with one next-pointer per descriptor index. Software or a producer engine enqueues a descriptor by presenting its byte address and a global queue number on a dedicated push channel. A consumer dequeues by reading that queue's pop location on a register bus, which returns the head descriptor's address and unlinks it. Because pushes have their own channel, a push and a pop can land on the same queue in the same clock.

Descriptor addresses become link indices through a small table of descriptor regions. Each region holds a base address, a descriptor count, a size exponent and the link index of its first descriptor. A pop turns the head index back into an address through the same table. Every queue keeps a head index, a tail index and an entry count, plus a status bit that is set while the queue holds anything. The instance owns a contiguous window of global queue numbers, starting at a parameterised base.

Top module: `desc_queue_mgr`

## Requirements
- R1: A push to a managed queue appends the descriptor, and successive pops of that queue return the pushed addresses in first-in first-out order, independently for every queue.
- R2: A pop of an empty queue returns 0 and leaves that queue's count and status unchanged.
- R3: Region r is programmed by bus writes with bus_addr[19:16]=4, bus_addr[5:2]=r and bus_addr[1:0] choosing the field: 0 base address, 1 descriptor count, 2 size exponent (clamped up to 4, i.e. 16 bytes), 3 first link index. An address A maps to index first + ((A - base) >> exponent) in the lowest-numbered region that holds it. A pop returns base + (offset << exponent), so low address bits below the descriptor size read back as zero.
- R4: A push whose address lies in no region, or maps to an index of NUM_DESC or above, is dropped and sets a sticky error flag. The flag appears on err_sticky and as bit 0 of a status read at offset 1, and only reset clears it.
- R5: A read with bus_addr[19:16]=2 and a managed queue number in bus_addr[13:0] returns that queue's entry count.
- R6: A read with bus_addr[19:16]=3 at offset 0 returns one bit per queue, with bit i set while queue QBASE+i is non-empty. The bit changes on the same clock edge as the push or pop that changes the count.
- R7: A push and a pop to the same queue in one cycle act as push-then-pop. On an empty queue the pop returns the address just pushed and the queue stays empty. Otherwise the head is returned and the count is unchanged.
- R8: Queue numbers outside QBASE..QBASE+NUM_Q-1 are ignored. A push to one changes no queue and sets no error, and a pop or peek of one returns 0. A pop is a read with bus_addr[19:16]=1.
- R9: After reset every queue is empty, the error flag is clear and every region has count 0, so any push is rejected as unmapped. Both ready outputs stay high, and bus_rvalid rises exactly one cycle after each accepted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| psh_valid | input | 1 | Push request |
| psh_ready | output | 1 | Push accepted (always high) |
| psh_queue | input | 14 | Global queue number for the push |
| psh_desc | input | 32 | Descriptor byte address to enqueue |
| bus_valid | input | 1 | Register bus request |
| bus_ready | output | 1 | Register bus accept (always high) |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 20 | [19:16] space select, [13:0] queue number or region/field |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read data valid, one cycle after the read |
| bus_rdata | output | 32 | Read data |
| err_sticky | output | 1 | Sticky dropped-push flag |

## Verification
The two functions that can fall in the same cycle are a push on the dedicated channel and a pop read on the register bus, aimed at the same queue. The bench drives both on one clock edge against a queue that holds zero, one and two entries. In each case the popped address, the following count and the later pop order are compared with a push-first model: the bypass return on an empty queue, the head handover on a single entry, and a plain head advance otherwise.

// File: rtl/dqm_pkg.sv
// Package: shared types and address-space codes of the descriptor queue manager.
// Assumes region fields fit 16 bits (link memory no deeper than 64K entries).
package dqm_pkg;

    typedef struct packed {
        logic [31:0] base;     // byte address of first descriptor
        logic [15:0] count;    // descriptors in region, 0 = disabled
        logic [4:0]  expo;     // log2 of descriptor size
        logic [15:0] first;    // link index of first descriptor
    } region_cfg_t;

    localparam logic [3:0] SPACE_POP    = 4'd1;
    localparam logic [3:0] SPACE_PEEK   = 4'd2;
    localparam logic [3:0] SPACE_STATUS = 4'd3;
    localparam logic [3:0] SPACE_CFG    = 4'd4;

endpackage

// File: rtl/dqm_region_map.sv
// Module: translates descriptor addresses to link indices (forward) and
// link indices back to addresses (reverse) through the region table.
// Assumes regions do not overlap; lowest region number wins on overlap.
module dqm_region_map
    import dqm_pkg::*;
#(
    parameter int NUM_REG  = 2,
    parameter int NUM_DESC = 32,
    parameter int IDX_W    = 5
) (
    input  region_cfg_t          cfg [NUM_REG],
    input  logic [31:0]          fwd_addr,
    output logic                 fwd_hit,
    output logic [IDX_W-1:0]     fwd_idx,
    input  logic [IDX_W-1:0]     rev_idx,
    output logic [31:0]          rev_addr
);
    logic [NUM_REG-1:0] hit_f;
    logic [IDX_W-1:0]   idx_f [NUM_REG];
    logic [NUM_REG-1:0] hit_r;
    logic [31:0]        addr_r [NUM_REG];

    for (genvar r = 0; r < NUM_REG; r++) begin : g_reg
        logic [4:0]  sh;
        logic [31:0] off;
        logic [32:0] gidx;
        logic [15:0] ridx;
        logic [15:0] roff;
        // Per-region forward and reverse lookup.
        always_comb begin
            sh       = (cfg[r].expo < 5'd4) ? 5'd4 : cfg[r].expo;
            off      = (fwd_addr - cfg[r].base) >> sh;
            gidx     = {17'b0, cfg[r].first} + {1'b0, off};
            hit_f[r] = (fwd_addr >= cfg[r].base) && (off < {16'b0, cfg[r].count})
                       && (gidx < 33'(NUM_DESC));
            idx_f[r] = gidx[IDX_W-1:0];
            ridx     = 16'(rev_idx);
            roff     = ridx - cfg[r].first;
            hit_r[r] = (ridx >= cfg[r].first) && (roff < cfg[r].count);
            addr_r[r] = cfg[r].base + (32'(roff) << sh);
        end
    end

    // Priority select: lowest-numbered matching region wins.
    always_comb begin
        fwd_hit  = 1'b0;
        fwd_idx  = '0;
        rev_addr = '0;
        for (int r = NUM_REG - 1; r >= 0; r--) begin
            if (hit_f[r]) begin
                fwd_hit = 1'b1;
                fwd_idx = idx_f[r];
            end
            if (hit_r[r]) rev_addr = addr_r[r];
        end
    end
endmodule

// File: rtl/dqm_link_ram.sv
// Module: next-pointer memory, one entry per descriptor index.
// One synchronous write port and one combinational read port; not reset,
// an entry is always written before the queue logic reads it.
module dqm_link_ram #(
    parameter int DEPTH = 32,
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [IDX_W-1:0] wdata,
    input  logic [IDX_W-1:0] raddr,
    output logic [IDX_W-1:0] rdata
);
    logic [IDX_W-1:0] mem [DEPTH];

    // Store a link when a push extends a non-empty list.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/dqm_queue_state.sv
// Module: per-queue head, tail, count and non-empty state with push/pop
// sequencing. A same-queue push and pop in one cycle act push-first.
// Assumes push_idx is not already linked into any queue.
module dqm_queue_state #(
    parameter int NUM_Q  = 8,
    parameter int QSEL_W = 3,
    parameter int IDX_W  = 5,
    parameter int CNT_W  = 6,
    parameter int MAX_CNT = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_en,
    input  logic [QSEL_W-1:0] push_q,
    input  logic [IDX_W-1:0]  push_idx,
    input  logic              pop_en,
    input  logic [QSEL_W-1:0] pop_q,
    input  logic [IDX_W-1:0]  link_next,
    output logic [IDX_W-1:0]  head_rd,
    output logic              link_we,
    output logic [IDX_W-1:0]  link_waddr,
    output logic [IDX_W-1:0]  link_wdata,
    output logic              pop_hit,
    output logic [IDX_W-1:0]  pop_idx,
    output logic [CNT_W-1:0]  cnt [NUM_Q],
    output logic [NUM_Q-1:0]  nonempty
);
    logic [IDX_W-1:0] head [NUM_Q];
    logic [IDX_W-1:0] tail [NUM_Q];
    logic [NUM_Q-1:0] pu, po;
    logic             pop_empty;

    // Decode which queue pushes and which pops with something to return.
    always_comb begin
        pop_empty = (cnt[pop_q] == '0);
        for (int q = 0; q < NUM_Q; q++) begin
            pu[q] = push_en && (push_q == QSEL_W'(q));
            po[q] = pop_en && (pop_q == QSEL_W'(q)) && ((cnt[q] != '0) || pu[q]);
        end
        pop_hit    = |po;
        pop_idx    = pop_empty ? push_idx : head[pop_q];
        head_rd    = head[pop_q];
        link_we    = push_en && (cnt[push_q] != '0);
        link_waddr = tail[push_q];
        link_wdata = push_idx;
    end

    // Advance list pointers and counts for every queue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int q = 0; q < NUM_Q; q++) begin
                head[q] <= '0;
                tail[q] <= '0;
                cnt[q]  <= '0;
            end
            nonempty <= '0;
        end else begin
            for (int q = 0; q < NUM_Q; q++) begin
                if (pu[q] && po[q]) begin
                    if (cnt[q] != '0) begin
                        tail[q] <= push_idx;
                        head[q] <= (cnt[q] == CNT_W'(1)) ? push_idx : link_next;
                    end
                end else if (pu[q]) begin
                    if (cnt[q] == '0) head[q] <= push_idx;
                    tail[q]     <= push_idx;
                    cnt[q]      <= cnt[q] + CNT_W'(1);
                    nonempty[q] <= 1'b1;
                end else if (po[q]) begin
                    head[q]     <= link_next;
                    cnt[q]      <= cnt[q] - CNT_W'(1);
                    nonempty[q] <= (cnt[q] != CNT_W'(1));
                end
            end
        end
    end

    for (genvar q = 0; q < NUM_Q; q++) begin : g_chk
        // R6: status bit tracks the count register on every edge.
        p_status_tracks_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
            nonempty[q] == (cnt[q] != '0));
        // R1: a queue never holds more entries than the link memory has.
        p_count_bounded_r1: assert property (@(posedge clk) disable iff (!rst_n)
            cnt[q] <= CNT_W'(MAX_CNT));
    end
endmodule

// File: rtl/desc_queue_mgr.sv
// Module: top of the linked-list descriptor queue manager. Push channel
// enqueues by address; register bus serves pop, peek, status and region
// setup. Assumes NUM_Q <= 32, NUM_Q >= 2, NUM_DESC <= 65536.
module desc_queue_mgr
    import dqm_pkg::*;
#(
    parameter int QBASE    = 64,
    parameter int NUM_Q    = 8,
    parameter int NUM_DESC = 32,
    parameter int NUM_REG  = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        psh_valid,
    output logic        psh_ready,
    input  logic [13:0] psh_queue,
    input  logic [31:0] psh_desc,
    input  logic        bus_valid,
    output logic        bus_ready,
    input  logic        bus_write,
    input  logic [19:0] bus_addr,
    input  logic [31:0] bus_wdata,
    output logic        bus_rvalid,
    output logic [31:0] bus_rdata,
    output logic        err_sticky
);
    localparam int IDX_W  = $clog2(NUM_DESC);
    localparam int QSEL_W = $clog2(NUM_Q);
    localparam int CNT_W  = $clog2(NUM_DESC + 1);

    region_cfg_t      cfg [NUM_REG];
    logic [3:0]       space;
    logic [13:0]      bq, bq_rel, pq_rel;
    logic             bq_in, pq_in, map_hit, push_en, pop_en, pop_hit;
    logic             link_we, cfg_we;
    logic [IDX_W-1:0] map_idx, pop_idx, head_rd, link_next, link_waddr, link_wdata;
    logic [31:0]      pop_addr;
    logic [CNT_W-1:0] cnt [NUM_Q];
    logic [NUM_Q-1:0] nonempty;

    assign psh_ready = 1'b1;
    assign bus_ready = 1'b1;

    // Decode queue windows and request kinds.
    always_comb begin
        space   = bus_addr[19:16];
        bq      = bus_addr[13:0];
        bq_rel  = bq - 14'(QBASE);
        pq_rel  = psh_queue - 14'(QBASE);
        bq_in   = (bq >= 14'(QBASE)) && (bq < 14'(QBASE + NUM_Q));
        pq_in   = (psh_queue >= 14'(QBASE)) && (psh_queue < 14'(QBASE + NUM_Q));
        push_en = psh_valid && pq_in && map_hit;
        pop_en  = bus_valid && !bus_write && (space == SPACE_POP) && bq_in;
        cfg_we  = bus_valid && bus_write && (space == SPACE_CFG);
    end

    dqm_region_map #(.NUM_REG(NUM_REG), .NUM_DESC(NUM_DESC), .IDX_W(IDX_W)) u_map (
        .cfg(cfg), .fwd_addr(psh_desc), .fwd_hit(map_hit), .fwd_idx(map_idx),
        .rev_idx(pop_idx), .rev_addr(pop_addr)
    );

    dqm_link_ram #(.DEPTH(NUM_DESC), .IDX_W(IDX_W)) u_link (
        .clk(clk), .we(link_we), .waddr(link_waddr), .wdata(link_wdata),
        .raddr(head_rd), .rdata(link_next)
    );

    dqm_queue_state #(.NUM_Q(NUM_Q), .QSEL_W(QSEL_W), .IDX_W(IDX_W),
                      .CNT_W(CNT_W), .MAX_CNT(NUM_DESC)) u_state (
        .clk(clk), .rst_n(rst_n),
        .push_en(push_en), .push_q(pq_rel[QSEL_W-1:0]), .push_idx(map_idx),
        .pop_en(pop_en), .pop_q(bq_rel[QSEL_W-1:0]), .link_next(link_next),
        .head_rd(head_rd), .link_we(link_we), .link_waddr(link_waddr),
        .link_wdata(link_wdata), .pop_hit(pop_hit), .pop_idx(pop_idx),
        .cnt(cnt), .nonempty(nonempty)
    );

    // Region table writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < NUM_REG; r++) cfg[r] <= '0;
        end else if (cfg_we) begin
            for (int r = 0; r < NUM_REG; r++) begin
                if (bus_addr[5:2] == 4'(r)) begin
                    case (bus_addr[1:0])
                        2'd0:    cfg[r].base  <= bus_wdata;
                        2'd1:    cfg[r].count <= bus_wdata[15:0];
                        2'd2:    cfg[r].expo  <= bus_wdata[4:0];
                        default: cfg[r].first <= bus_wdata[15:0];
                    endcase
                end
            end
        end
    end

    // Sticky flag for pushes that map to no descriptor.
    always_ff @(posedge clk) begin
        if (!rst_n) err_sticky <= 1'b0;
        else if (psh_valid && pq_in && !map_hit) err_sticky <= 1'b1;
    end

    // Registered read response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rvalid <= 1'b0;
            bus_rdata  <= '0;
        end else begin
            bus_rvalid <= bus_valid && !bus_write;
            if (bus_valid && !bus_write) begin
                case (space)
                    SPACE_POP:    bus_rdata <= pop_hit ? pop_addr : 32'd0;
                    SPACE_PEEK:   bus_rdata <= bq_in ? 32'(cnt[bq_rel[QSEL_W-1:0]]) : 32'd0;
                    SPACE_STATUS: bus_rdata <= (bq == 14'd0) ? 32'(nonempty) :
                                               (bq == 14'd1) ? {31'd0, err_sticky} : 32'd0;
                    default:      bus_rdata <= 32'd0;
                endcase
            end
        end
    end

    // R9: a read is answered on the next cycle.
    p_read_answered_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write) |=> bus_rvalid);
    // R4: once set, the error flag stays set.
    p_err_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        err_sticky |=> err_sticky);
    // R4: an unmapped push to a managed queue raises the flag.
    p_unmapped_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (psh_valid && pq_in && !map_hit) |=> err_sticky);
    // R2: popping with nothing to return yields zero.
    p_empty_pop_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_en && !pop_hit) |=> (bus_rdata == 32'd0));
endmodule

// File: tb/desc_queue_mgr_bench.sv
`timescale 1ns/1ps
module desc_queue_mgr_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psh_valid = 1'b0;
    logic        psh_ready;
    logic [13:0] psh_queue = '0;
    logic [31:0] psh_desc = '0;
    logic        bus_valid = 1'b0;
    logic        bus_ready;
    logic        bus_write = 1'b0;
    logic [19:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rvalid;
    logic [31:0] bus_rdata;
    logic        err_sticky;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    logic [31:0] mq [8][$];

    always #2 clk = ~clk;

    desc_queue_mgr u_desc_queue_mgr (
        .clk(clk), .rst_n(rst_n), .psh_valid(psh_valid), .psh_ready(psh_ready),
        .psh_queue(psh_queue), .psh_desc(psh_desc), .bus_valid(bus_valid),
        .bus_ready(bus_ready), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
        .err_sticky(err_sticky)
    );

    function automatic logic [31:0] a0(int i); return 32'h1000_0000 + 32'(i * 64); endfunction
    function automatic logic [31:0] a1(int i); return 32'h2000_0000 + 32'(i * 128); endfunction

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(logic [3:0] sp, logic [15:0] off, logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = {sp, off}; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(logic [3:0] sp, logic [15:0] off, output logic [31:0] d, input string req);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = {sp, off};
        @(negedge clk);
        bus_valid = 1'b0;
        check(bus_rvalid === 1'b1, req, 32'(bus_rvalid), 32'd1);
        d = bus_rdata;
    endtask

    task automatic push(int q, logic [31:0] a);
        @(negedge clk);
        psh_valid = 1'b1; psh_queue = 14'(q); psh_desc = a;
        @(negedge clk);
        psh_valid = 1'b0;
    endtask

    task automatic expect_rd(logic [3:0] sp, int off, logic [31:0] exp, string req);
        logic [31:0] d;
        rd(sp, 16'(off), d, req);
        check(d === exp, req, d, exp);
    endtask

    task automatic configure();
        wr(4'd4, 16'h0000, 32'h1000_0000);
        wr(4'd4, 16'h0001, 32'd16);
        wr(4'd4, 16'h0002, 32'd6);
        wr(4'd4, 16'h0003, 32'd0);
        wr(4'd4, 16'h0004, 32'h2000_0000);
        wr(4'd4, 16'h0005, 32'd12);
        wr(4'd4, 16'h0006, 32'd7);
        wr(4'd4, 16'h0007, 32'd20);
    endtask

    // R9: reset values and rejection before any region is set up.
    task automatic t_reset();
        check(err_sticky === 1'b0, "R9 err after reset", 32'(err_sticky), 0);
        check(psh_ready === 1'b1 && bus_ready === 1'b1, "R9 ready", 32'({psh_ready, bus_ready}), 3);
        expect_rd(4'd3, 0, 32'd0, "R9 status after reset");
        expect_rd(4'd2, 64, 32'd0, "R9 peek after reset");
        push(64, a0(0));
        check(err_sticky === 1'b1, "R9 push before config rejected", 32'(err_sticky), 1);
        expect_rd(4'd2, 64, 32'd0, "R9 queue unchanged");
    endtask

    // R1 R5 R6: simple push/pop with counts and status.
    task automatic t_basic();
        push(64, a0(1)); push(64, a0(2)); push(64, a0(3));
        expect_rd(4'd2, 64, 32'd3, "R5 peek count");
        expect_rd(4'd3, 0, 32'h1, "R6 status bit set");
        expect_rd(4'd1, 64, a0(1), "R1 pop first");
        expect_rd(4'd1, 64, a0(2), "R1 pop second");
        expect_rd(4'd2, 64, 32'd1, "R5 peek after pops");
        expect_rd(4'd1, 64, a0(3), "R1 pop third");
        expect_rd(4'd3, 0, 32'h0, "R6 status cleared");
    endtask

    // R2: empty pop.
    task automatic t_empty();
        expect_rd(4'd1, 65, 32'd0, "R2 empty pop returns 0");
        expect_rd(4'd2, 65, 32'd0, "R2 count stays 0");
        expect_rd(4'd3, 0, 32'h0, "R2 status unchanged");
    endtask

    // R3: region mapping round trip and alignment.
    task automatic t_map();
        push(66, a1(0)); push(66, a1(11)); push(66, a0(2) + 32'd5);
        expect_rd(4'd2, 66, 32'd3, "R3 all three mapped");
        expect_rd(4'd1, 66, a1(0), "R3 region1 first");
        expect_rd(4'd1, 66, a1(11), "R3 region1 last");
        expect_rd(4'd1, 66, a0(2), "R3 unaligned reads back aligned");
    endtask

    // R1: interleaved queues against a model.
    task automatic t_interleave();
        logic [31:0] d;
        for (int k = 0; k < 24; k++) begin
            logic [31:0] a;
            int q;
            a = (k < 12) ? a0(k) : a1(k - 12);
            q = (k * 5) % 8;
            push(64 + q, a);
            mq[q].push_back(a);
        end
        for (int q = 0; q < 8; q++)
            expect_rd(4'd2, 64 + q, 32'(mq[q].size()), "R5 interleaved count");
        for (int r = 0; r < 3; r++) begin
            for (int q = 7; q >= 0; q--) begin
                if (mq[q].size() > 0) begin
                    logic [31:0] e;
                    e = mq[q].pop_front();
                    rd(4'd1, 16'(64 + q), d, "R1 interleaved pop");
                    check(d === e, "R1 interleaved FIFO order", d, e);
                end
            end
        end
        expect_rd(4'd3, 0, 32'h0, "R6 all drained");
    endtask

    task automatic same_cycle(int q, logic [31:0] a, logic [31:0] exp, string req);
        @(negedge clk);
        psh_valid = 1'b1; psh_queue = 14'(q); psh_desc = a;
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = {4'd1, 16'(q)};
        @(negedge clk);
        psh_valid = 1'b0; bus_valid = 1'b0;
        check(bus_rdata === exp, req, bus_rdata, exp);
    endtask

    // R7: same-cycle push and pop on one queue.
    task automatic t_same();
        same_cycle(67, a0(4), a0(4), "R7 empty bypass");
        expect_rd(4'd2, 67, 32'd0, "R7 empty stays empty");
        push(67, a0(5));
        same_cycle(67, a0(6), a0(5), "R7 single entry head");
        expect_rd(4'd2, 67, 32'd1, "R7 count held at 1");
        expect_rd(4'd1, 67, a0(6), "R7 pushed becomes head");
        push(67, a0(7)); push(67, a0(8));
        same_cycle(67, a0(9), a0(7), "R7 multi entry head");
        expect_rd(4'd2, 67, 32'd2, "R7 count held at 2");
        expect_rd(4'd1, 67, a0(8), "R7 order after");
        expect_rd(4'd1, 67, a0(9), "R7 tail after");
    endtask

    // R8: queue numbers outside the window.
    task automatic t_range();
        push(10, a0(10)); push(72, a0(11));
        check(err_sticky === 1'b0, "R8 no error", 32'(err_sticky), 0);
        expect_rd(4'd3, 0, 32'h0, "R8 no queue touched");
        expect_rd(4'd1, 10, 32'd0, "R8 pop outside");
        expect_rd(4'd2, 72, 32'd0, "R8 peek outside");
    endtask

    // R4: unmapped and over-depth pushes.
    task automatic t_err();
        push(68, 32'h3000_0000);
        check(err_sticky === 1'b1, "R4 unmapped flags", 32'(err_sticky), 1);
        expect_rd(4'd3, 1, 32'd1, "R4 status word");
        expect_rd(4'd2, 68, 32'd0, "R4 dropped");
        do_reset();
        configure();
        push(68, a1(12));
        check(err_sticky === 1'b1, "R4 index past depth flags", 32'(err_sticky), 1);
        expect_rd(4'd2, 68, 32'd0, "R4 past depth dropped");
        push(68, a0(1));
        check(err_sticky === 1'b1, "R4 flag sticky", 32'(err_sticky), 1);
        expect_rd(4'd1, 68, a0(1), "R4 good push still works");
    endtask

    initial begin
        do_reset();
        t_reset();
        do_reset();
        configure();
        t_basic();
        t_empty();
        t_map();
        t_interleave();
        t_same();
        t_range();
        t_err();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule